// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block is a register-mapped real-time clock. It keeps a 32-bit unsigned count of seconds. A prescaler divides the input clock into a one-second update strobe. Software can preload a new time, which takes effect at the next update. It can also program a match value; when the count reaches that value, an alarm interrupt is raised.

Software talks to the block over a simple single-cycle register bus. The bus carries a word index, a write strobe with write data, and a read strobe. Read data returns registered, on the clock edge that accepts the read. A control register holds four bits:

- counter run
- interrupt enable
- interrupt mask
- wrap enable

The alarm has a raw sticky status bit and a separate masked status bit. It is acknowledged by reading a dedicated acknowledge register. A constant identification word can be read from the register map.

Top module: `sec_rtc`

## Requirements
- R1: After synchronous reset, the count, match, load, control and raw status registers all read 0, and `irq` is low.
- R2: While control bit 2 (run) is 1, the count changes exactly once every PRESCALE clock cycles. The first change lands on the PRESCALE-th rising edge after the edge that set run. A normal change adds one.
- R3: While run is 0, the count holds its value and the prescaler phase returns to zero. Setting run again restarts the full PRESCALE-cycle interval.
- R4: A write to word index 2 (load) does not alter the count immediately. At the next update the count takes the loaded value instead of incrementing, and counting continues from it.
- R5: At count 0xFFFFFFFF, an update yields 0 when control bit 3 (wrap) is 1. It keeps 0xFFFFFFFF when wrap is 0.
- R6: When an update changes the count to the value in word index 1 (match), bit 0 of word index 5 (raw status) becomes 1. It stays 1 until acknowledged.
- R7: `irq` and bit 0 of word index 4 (masked status) equal raw status AND control bit 0 (enable) AND NOT control bit 1 (mask).
- R8: A read of word index 6 (acknowledge) clears raw status and returns 0. If a match occurs on the same edge, the status stays set.
- R9: Word index 7 returns the VERSION parameter. Writes to word indices 0, 4, 5, 6 and 7 change nothing.
- R10: The control register reads back only its low four bits, with the upper bits 0. The match and load registers read back the last value written. Read data appears on the edge that accepts the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked alarm interrupt, level |

## Verification
The assertions check the following on every cycle:
- the count moves only on an update strobe, and each move is one of increment, load transfer, wrap or saturate;
- raw status is sticky and always sets on a match;
- an acknowledge without a coincident match clears raw status;
- a set mask always silences the interrupt.

Only the directed scenarios can show the rest: the absolute timing of the first update after enabling, the deferral of a load until the next second, the ordering when a match and an acknowledge land on the same edge, and the value returned by each register.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        RG_COUNT = 3'd0,
        RG_MATCH = 3'd1,
        RG_LOAD  = 3'd2,
        RG_CTRL  = 3'd3,
        RG_STAT  = 3'd4,
        RG_RAW   = 3'd5,
        RG_ACK   = 3'd6,
        RG_VER   = 3'd7
    } reg_sel_e;

    // packed: wrap is bit 3, run bit 2, mask bit 1, ie bit 0
    typedef struct packed {
        logic wrap;
        logic run;
        logic mask;
        logic ie;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e idx_to_sel(input logic [IDX_W-1:0] idx);
        return reg_sel_e'(idx);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        return {{(DATA_W-4){1'b0}}, c};
    endfunction

    function automatic logic [DATA_W-1:0] flag_word(input logic f);
        return {{(DATA_W-1){1'b0}}, f};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + CW'(1);
        end
    end

    assign tick = run && (phase == LAST);

    // R2: strobes are isolated single cycles for DIV >= 2
    p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R3: a stopped prescaler emits no strobe on the next cycle
    p_stop_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wrap,
    input  logic         load_wr,
    input  logic [W-1:0] load_data,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] count,
    output logic [W-1:0] load_val,
    output logic         hit
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic         pend;
    logic [W-1:0] nxt;

    always_comb begin
        if (pend) begin
            nxt = load_val;
        end else if (count == ALL_ONES) begin
            nxt = wrap ? '0 : count;
        end else begin
            nxt = count + W'(1);
        end
    end

    assign hit = tick && (nxt != count) && (nxt == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick) begin
            count <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_val <= '0;
            pend     <= 1'b0;
        end else begin
            if (load_wr) begin
                load_val <= load_data;
            end
            if (load_wr) begin
                pend <= 1'b1;
            end else if (tick) begin
                pend <= 1'b0;
            end
        end
    end

    // R4: count never moves between update strobes
    p_no_early_load_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R4: a pending load is transferred at the strobe
    p_load_xfer_r4: assert property (@(posedge clk) disable iff (rst)
        tick && pend |=> count == $past(load_val));

    // R2: ordinary update adds one
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick && !pend && (count != ALL_ONES) |=> count == $past(count) + W'(1));

    // R5: wrap and saturate at the top of the range
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        tick && !pend && (count == ALL_ONES) && wrap |=> count == '0);
    p_sat_r5: assert property (@(posedge clk) disable iff (rst)
        tick && !pend && (count == ALL_ONES) && !wrap |=> count == ALL_ONES);

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
    import sec_rtc_pkg::*;
#(
    parameter logic [DATA_W-1:0] VERSION = 32'h0002_0101
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] load_val,
    input  logic              hit,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] match_val,
    output logic              load_wr,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic raw;
    logic ack_rd;
    logic masked;

    assign load_wr = req.wr && (req.sel == RG_LOAD);
    assign ack_rd  = req.rd && (req.sel == RG_ACK);
    assign masked  = raw && ctrl.ie && !ctrl.mask;
    assign irq     = masked;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            match_val <= '0;
        end else if (req.wr) begin
            case (req.sel)
                RG_CTRL:  ctrl      <= ctrl_t'(req.data[3:0]);
                RG_MATCH: match_val <= req.data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= 1'b0;
        end else if (hit) begin
            raw <= 1'b1;
        end else if (ack_rd) begin
            raw <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            case (req.sel)
                RG_COUNT: rdata <= count;
                RG_MATCH: rdata <= match_val;
                RG_LOAD:  rdata <= load_val;
                RG_CTRL:  rdata <= ctrl_word(ctrl);
                RG_STAT:  rdata <= flag_word(masked);
                RG_RAW:   rdata <= flag_word(raw);
                RG_ACK:   rdata <= '0;
                RG_VER:   rdata <= VERSION;
                default:  rdata <= '0;
            endcase
        end
    end

    // R6: a match always leaves raw status set
    p_hit_sets_r6: assert property (@(posedge clk) disable iff (rst)
        hit |=> raw);
    // R6: raw status is sticky without an acknowledge
    p_raw_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        raw && !ack_rd |=> raw);
    // R8: acknowledge without a coincident match clears the status
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ack_rd && !hit |=> !raw);
    // R7: a set mask keeps the interrupt low
    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl.mask |-> !irq);
    // R9: identification read returns the constant
    p_version_r9: assert property (@(posedge clk) disable iff (rst)
        req.rd && (req.sel == RG_VER) |=> rdata == VERSION);

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int                PRESCALE = 32768,
    parameter logic [DATA_W-1:0] VERSION  = 32'h0002_0101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    bus_req_t          req;
    ctrl_t             ctrl;
    logic              tick;
    logic              hit;
    logic              load_wr;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] match_val;

    assign req.wr   = bus_wr;
    assign req.rd   = bus_rd;
    assign req.sel  = idx_to_sel(bus_addr);
    assign req.data = bus_wdata;

    rtc_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .tick (tick)
    );

    rtc_counter #(.W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wrap      (ctrl.wrap),
        .load_wr   (load_wr),
        .load_data (bus_wdata),
        .match_val (match_val),
        .count     (count),
        .load_val  (load_val),
        .hit       (hit)
    );

    rtc_regs #(.VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .count     (count),
        .load_val  (load_val),
        .hit       (hit),
        .ctrl      (ctrl),
        .match_val (match_val),
        .load_wr   (load_wr),
        .rdata     (bus_rdata),
        .irq       (irq)
    );

    // R3: with run clear the count cannot move
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |=> $stable(count));

endmodule

// File: tb/sec_rtc_tb.sv
module sec_rtc_tb;

    localparam int          DIV = 8;
    localparam logic [31:0] VER = 32'h0002_0101;
    localparam logic [2:0]  A_CNT = 3'd0, A_MAT = 3'd1, A_LD = 3'd2, A_CTL = 3'd3,
                            A_STA = 3'd4, A_RAW = 3'd5, A_ACK = 3'd6, A_VER = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int en_edge = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sec_rtc #(.PRESCALE(DIV), .VERSION(VER)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // the read is accepted on rising edge number t
    task automatic rd_at(input int t, input logic [2:0] a, output logic [31:0] d);
        while (cyc < t - 1) begin
            @(posedge clk); #1;
        end
        rd(a, d);
    endtask

    task automatic enable(input logic [31:0] bits);
        wr(A_CTL, 32'h0);
        wr(A_CTL, bits);
        en_edge = cyc;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CNT, v); chk("R1 count", v, 32'h0);
        rd(A_CTL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_RAW, v); chk("R1 raw", v, 32'h0);
        rd(A_MAT, v); chk("R1 match", v, 32'h0);
        rd(A_LD, v);  chk("R1 load", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(A_CTL, 32'hFFFF_FFF0); rd(A_CTL, v); chk("R10 ctrl upper", v, 32'h0);
        wr(A_CTL, 32'h0000_0013); rd(A_CTL, v); chk("R10 ctrl low", v, 32'h3);
        wr(A_CTL, 32'h0);
        wr(A_MAT, 32'hA5A5_1234); rd(A_MAT, v); chk("R10 match", v, 32'hA5A5_1234);
    endtask

    task automatic t_count_load;
        logic [31:0] v;
        wr(A_LD, 32'd100);
        rd(A_LD, v);  chk("R10 load", v, 32'd100);
        rd(A_CNT, v); chk("R4 not immediate", v, 32'd0);
        enable(32'h4);
        rd_at(en_edge + DIV/2, A_CNT, v);   chk("R2 mid first second", v, 32'd0);
        rd_at(en_edge + DIV, A_CNT, v);     chk("R2 before first edge", v, 32'd0);
        rd_at(en_edge + DIV + 1, A_CNT, v); chk("R4 load transfer", v, 32'd100);
        rd_at(en_edge + 2*DIV + 4, A_CNT, v); chk("R2 step", v, 32'd101);
        rd_at(en_edge + 3*DIV + 4, A_CNT, v); chk("R2 step2", v, 32'd102);
        wr(A_LD, 32'd500);
        rd(A_CNT, v); chk("R4 deferred", v, 32'd102);
        rd_at(en_edge + 4*DIV + 4, A_CNT, v); chk("R4 mid-run load", v, 32'd500);
        rd_at(en_edge + 5*DIV + 4, A_CNT, v); chk("R4 continue", v, 32'd501);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        wr(A_CTL, 32'h0);
        repeat (5*DIV) begin @(posedge clk); #1; end
        rd(A_CNT, v); chk("R3 hold", v, 32'd501);
        enable(32'h4);
        rd_at(en_edge + DIV, A_CNT, v);     chk("R3 restart phase", v, 32'd501);
        rd_at(en_edge + DIV + 1, A_CNT, v); chk("R3 resume", v, 32'd502);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(A_CTL, 32'h0);
        wr(A_LD, 32'hFFFF_FFFE);
        enable(32'h4);
        rd_at(en_edge + DIV + 4, A_CNT, v);   chk("R5 load top", v, 32'hFFFF_FFFE);
        rd_at(en_edge + 2*DIV + 4, A_CNT, v); chk("R5 all ones", v, 32'hFFFF_FFFF);
        rd_at(en_edge + 3*DIV + 4, A_CNT, v); chk("R5 saturate", v, 32'hFFFF_FFFF);
        enable(32'hC);
        rd_at(en_edge + DIV + 4, A_CNT, v);   chk("R5 wrap", v, 32'h0);
        rd_at(en_edge + 2*DIV + 4, A_CNT, v); chk("R5 after wrap", v, 32'h1);
    endtask

    task automatic t_match;
        logic [31:0] v;
        wr(A_CTL, 32'h0);
        rd(A_ACK, v); chk("R8 ack reads zero", v, 32'h0);
        wr(A_LD, 32'd50);
        wr(A_MAT, 32'd52);
        enable(32'h5);
        rd_at(en_edge + DIV + 4, A_CNT, v); chk("R6 cnt50", v, 32'd50);
        rd(A_RAW, v); chk("R6 raw before", v, 32'h0);
        rd_at(en_edge + 2*DIV + 4, A_RAW, v); chk("R6 raw at 51", v, 32'h0);
        rd_at(en_edge + 3*DIV + 2, A_CNT, v); chk("R6 cnt52", v, 32'd52);
        rd(A_RAW, v); chk("R6 raw set", v, 32'h1);
        rd(A_STA, v); chk("R7 status", v, 32'h1);
        chk("R7 irq on", {31'b0, irq}, 32'h1);
        wr(A_CTL, 32'h7);
        chk("R7 irq masked", {31'b0, irq}, 32'h0);
        rd(A_STA, v); chk("R7 status masked", v, 32'h0);
        rd(A_RAW, v); chk("R6 raw kept", v, 32'h1);
        wr(A_CTL, 32'h4);
        chk("R7 irq no enable", {31'b0, irq}, 32'h0);
        wr(A_CTL, 32'h5);
        chk("R7 irq back", {31'b0, irq}, 32'h1);
        rd(A_ACK, v);
        chk("R8 irq cleared", {31'b0, irq}, 32'h0);
        rd(A_RAW, v); chk("R8 raw cleared", v, 32'h0);
        wr(A_MAT, 32'd55);
        rd_at(en_edge + 6*DIV, A_ACK, v);
        rd(A_RAW, v); chk("R8 match wins", v, 32'h1);
        chk("R8 irq held", {31'b0, irq}, 32'h1);
        rd(A_ACK, v);
        rd(A_RAW, v); chk("R8 cleared later", v, 32'h0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        rd(A_VER, v); chk("R9 version", v, VER);
        rd(A_CNT, v); chk("R9 count base", v, 32'd55);
        wr(A_CNT, 32'hDEAD_BEEF);
        wr(A_VER, 32'h0);
        wr(A_STA, 32'h1);
        wr(A_RAW, 32'h1);
        wr(A_ACK, 32'h1);
        rd(A_CNT, v); chk("R9 count unwritten", v, 32'd55);
        rd(A_VER, v); chk("R9 version unwritten", v, VER);
        rd(A_RAW, v); chk("R9 raw unwritten", v, 32'h0);
        rd(A_CTL, v); chk("R9 ctrl unchanged", v, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset;
        t_readback;
        t_count_load;
        t_hold;
        t_wrap;
        t_match;
        t_readonly;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual running expected done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule